// File: doc/BRIEF.md
# SPI Half-Duplex Transaction Sequencer

This block runs half-duplex SPI transactions of the kind used to talk to serial flash. Software loads a command word, up to eight 32-bit data words and one register holding three bit counts, then sets a start bit and polls a busy flag until the transaction ends. The transaction has three phases, always in the same order. First the command word is sent. Then extra transmit bits are taken from the data words. Last, receive bits are captured back into those same data words. A phase whose count is zero is skipped.

The block does not shift bits on the wire itself. It hands transmit bits to a separate serializer over a valid/ready bit stream and takes receive bits back over a second valid/ready stream. The serializer is free to stall either stream for any number of cycles. On the transmit stream, once `tx_valid` is high it stays high and `tx_bit` stays constant until a cycle in which `tx_ready` is also high; that cycle consumes the bit. On the receive stream, `rx_ready` is high only during the receive phase, and a bit is stored in every cycle in which `rx_valid` and `rx_ready` are both high. The block also drives active-low chip selects from a software register, and passes a configuration word through to the serializer.

Register map (byte addresses): 0x00 control/status, 0x04 command word, 0x08 + 4k data word k (k = 0..7), 0x28 serializer configuration, 0x2C counts, 0x38 chip-select enables.

Top module: `spi_xact_seq`

## Requirements
- R1: Software can write and read back the command word (0x04), data word k (0x08+4k), the configuration word (0x28), the counts register (0x2C) and the chip-select register (0x38). The configuration word appears unchanged on `ser_cfg`. Control bits [7:0] are a storage field that reads back and has no effect. Control bit 16 reads as busy.
- R2: A write to 0x00 with bit 8 set, made while idle, starts a transaction, and busy reads 1 from the next cycle. A start written while busy is ignored: the transaction in progress is not restarted.
- R3: The phases run as command, then extra transmit, then receive. A phase with a zero count emits and accepts no bits.
- R4: Counts bits [31:24] set the number of command bits, and any value above 32 is treated as 32. Command bits go out starting at command bit 31 and moving downward, so the most significant byte leaves first.
- R5: Counts bits [11:0] set the number of extra transmit bits, and any value above 256 is treated as 256. Buffer byte b is bits [8(b mod 4)+7 : 8(b mod 4)] of data word b/4. Bytes are sent in rising b order, and each byte is sent most significant bit first.
- R6: Counts bits [23:12] set the number of receive bits, and any value above 256 is treated as 256. Receive bit i is written to bit 7-(i mod 8) of buffer byte i/8. Every buffer bit that is not received keeps its value.
- R7: Busy falls on the clock edge that consumes the final bit of the transaction. A start with all three counts zero holds busy high for exactly one cycle.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_bit` stays stable. `tx_valid` is high only in the command and extra transmit phases, and `rx_ready` is high only in the receive phase.
- R9: `cs_n[n]` is low exactly when bit n of the chip-select register is 1.
- R10: Writes to the command word, the counts register or any data word are ignored while busy.
- R11: After reset, every register reads 0, busy is 0, `tx_valid` and `rx_ready` are 0, and every `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| tx_valid | output | 1 | Transmit bit available |
| tx_ready | input | 1 | Serializer takes the transmit bit |
| tx_bit | output | 1 | Transmit bit value |
| rx_valid | input | 1 | Serializer offers a receive bit |
| rx_ready | output | 1 | Block accepts a receive bit |
| rx_bit | input | 1 | Receive bit value |
| cs_n | output | 2 | Active-low chip selects |
| ser_cfg | output | 32 | Configuration word for the serializer |

## Verification
A wrong phase or bit counter shows up on `tx_bit` as soon as the wrong bit is offered. The bench compares the transmit stream bit by bit, so a skipped, repeated or reordered bit fails the run in that transaction. A wrong receive position does not show on any pin until software reads the data words back after busy falls. For that reason each transaction ends with a full read-back against a byte model, including the bits that must not change. A busy flag that falls one cycle early or late is caught by counting cycles from the final handshake.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_TX,
    ST_RX,
    ST_DONE
  } phase_e;

  // Word addresses: byte address bits [5:2]
  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_CMD   = 4'd1;
  localparam logic [3:0] A_DATA0 = 4'd2;
  localparam logic [3:0] A_CFG   = 4'd10;
  localparam logic [3:0] A_CNT   = 4'd11;
  localparam logic [3:0] A_CS    = 4'd14;

  localparam int START_BIT = 8;

endpackage

// File: rtl/spi_xact_regs.sv
module spi_xact_regs
  import spi_xact_pkg::*;
#(
  parameter int DATA_WORDS = 8,
  parameter int NUM_CS     = 2,
  localparam int BUF_BITS  = DATA_WORDS * 32,
  localparam int POS_W     = $clog2(BUF_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [5:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                busy,
  input  logic                rx_we,
  input  logic [POS_W-1:0]    rx_pos,
  input  logic                rx_val,
  output logic                start_req,
  output logic [31:0]         cmd_q,
  output logic [31:0]         counts_q,
  output logic [31:0]         cfg_q,
  output logic [NUM_CS-1:0]   cs_q,
  output logic [BUF_BITS-1:0] buf_flat
);

  logic [3:0]  waddr;
  logic [1:0]  unused_lsb;
  logic [7:0]  legacy_q;
  logic [31:0] word_q [DATA_WORDS];

  assign waddr      = bus_addr[5:2];
  assign unused_lsb = bus_addr[1:0];
  assign start_req  = bus_we && (waddr == A_CTRL) && bus_wdata[START_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      legacy_q <= '0;
      cmd_q    <= '0;
      counts_q <= '0;
      cfg_q    <= '0;
      cs_q     <= '0;
    end else if (bus_we) begin
      if (waddr == A_CTRL) legacy_q <= bus_wdata[7:0];
      if (waddr == A_CFG)  cfg_q    <= bus_wdata;
      if (waddr == A_CS)   cs_q     <= bus_wdata[NUM_CS-1:0];
      if (!busy && waddr == A_CMD) cmd_q    <= bus_wdata;
      if (!busy && waddr == A_CNT) counts_q <= bus_wdata;
    end
  end

  // One storage word per data slot; bus writes blocked while busy
  for (genvar k = 0; k < DATA_WORDS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[k] <= '0;
      end else if (bus_we && !busy && waddr == 4'(A_DATA0 + k)) begin
        word_q[k] <= bus_wdata;
      end else if (rx_we && rx_pos[POS_W-1:5] == (POS_W-5)'(k)) begin
        word_q[k][rx_pos[4:0]] <= rx_val;
      end
    end
    assign buf_flat[32*k +: 32] = word_q[k];
  end

  always_comb begin
    bus_rdata = '0;
    if (waddr == A_CTRL) bus_rdata = {15'd0, busy, 8'd0, legacy_q};
    if (waddr == A_CMD)  bus_rdata = cmd_q;
    if (waddr == A_CFG)  bus_rdata = cfg_q;
    if (waddr == A_CNT)  bus_rdata = counts_q;
    if (waddr == A_CS)   bus_rdata = 32'(cs_q);
    for (int k = 0; k < DATA_WORDS; k++) begin
      if (waddr == 4'(A_DATA0 + k)) bus_rdata = word_q[k];
    end
  end

  // R10: command word cannot move under a running transaction
  p_cmd_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_q));
  p_counts_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(counts_q));

endmodule

// File: rtl/spi_xact_ctrl.sv
module spi_xact_ctrl
  import spi_xact_pkg::*;
#(
  parameter int DATA_WORDS = 8,
  parameter int CMD_BITS   = 32,
  localparam int BUF_BITS  = DATA_WORDS * 32,
  localparam int POS_W     = $clog2(BUF_BITS),
  localparam int CNT_W     = $clog2(BUF_BITS + 1),
  localparam int CIDX_W    = $clog2(CMD_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  logic [31:0]         cmd_q,
  input  logic [31:0]         counts_q,
  input  logic [BUF_BITS-1:0] buf_flat,
  input  logic                tx_ready,
  input  logic                rx_valid,
  input  logic                rx_bit,
  output logic                busy,
  output logic                tx_valid,
  output logic                tx_bit,
  output logic                rx_ready,
  output logic                rx_we,
  output logic [POS_W-1:0]    rx_pos,
  output logic                rx_val
);

  phase_e            st;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cmd_n, tx_n, rx_n;
  logic [7:0]        cmd_f;
  logic [11:0]       tx_f, rx_f;
  logic [POS_W-1:0]  bit_pos;
  logic [CIDX_W-1:0] cidx;
  logic              tx_fire, rx_fire, cnt_last;
  phase_e            first_ph, after_cmd, after_tx;

  // Field decode with saturation at the phase limits
  assign cmd_f = counts_q[31:24];
  assign rx_f  = counts_q[23:12];
  assign tx_f  = counts_q[11:0];
  assign cmd_n = (cmd_f > 8'(CMD_BITS)) ? CNT_W'(CMD_BITS) : CNT_W'(cmd_f);
  assign tx_n  = (tx_f > 12'(BUF_BITS)) ? CNT_W'(BUF_BITS) : CNT_W'(tx_f);
  assign rx_n  = (rx_f > 12'(BUF_BITS)) ? CNT_W'(BUF_BITS) : CNT_W'(rx_f);

  assign after_tx  = (rx_n != '0) ? ST_RX : ST_IDLE;
  assign after_cmd = (tx_n != '0) ? ST_TX : after_tx;
  assign first_ph  = (cmd_n != '0) ? ST_CMD :
                     (tx_n != '0)  ? ST_TX  :
                     (rx_n != '0)  ? ST_RX  : ST_DONE;

  // Byte-ascending, MSB-first position within the shared buffer
  assign bit_pos = {cnt[POS_W-1:3], ~cnt[2:0]};
  assign cidx    = CIDX_W'(CMD_BITS - 1) - cnt[CIDX_W-1:0];

  assign busy     = (st != ST_IDLE);
  assign tx_valid = (st == ST_CMD) || (st == ST_TX);
  assign tx_bit   = (st == ST_CMD) ? cmd_q[cidx] : buf_flat[bit_pos];
  assign rx_ready = (st == ST_RX);
  assign tx_fire  = tx_valid && tx_ready;
  assign rx_fire  = rx_ready && rx_valid;

  always_comb begin
    cnt_last = 1'b0;
    case (st)
      ST_CMD:  cnt_last = (cnt == cmd_n - CNT_W'(1));
      ST_TX:   cnt_last = (cnt == tx_n - CNT_W'(1));
      ST_RX:   cnt_last = (cnt == rx_n - CNT_W'(1));
      default: cnt_last = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start_req) begin
          cnt <= '0;
          st  <= first_ph;
        end
        ST_CMD: if (tx_fire) begin
          cnt <= cnt_last ? '0 : cnt + CNT_W'(1);
          if (cnt_last) st <= after_cmd;
        end
        ST_TX: if (tx_fire) begin
          cnt <= cnt_last ? '0 : cnt + CNT_W'(1);
          if (cnt_last) st <= after_tx;
        end
        ST_RX: if (rx_fire) begin
          cnt <= cnt_last ? '0 : cnt + CNT_W'(1);
          if (cnt_last) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rx_we  = rx_fire;
  assign rx_pos = bit_pos;
  assign rx_val = rx_bit;

  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && start_req) |=> busy);
  p_zero_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && start_req && cmd_n == '0 && tx_n == '0 && rx_n == '0)
      |=> busy ##1 !busy);
  p_rx_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && cnt_last) |=> !busy);
  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_bit)));

endmodule

// File: rtl/spi_xact_seq.sv
module spi_xact_seq
  import spi_xact_pkg::*;
#(
  parameter int DATA_WORDS = 8,
  parameter int NUM_CS     = 2,
  parameter int CMD_BITS   = 32,
  localparam int BUF_BITS  = DATA_WORDS * 32,
  localparam int POS_W     = $clog2(BUF_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_bit,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_bit,
  output logic [NUM_CS-1:0] cs_n,
  output logic [31:0]       ser_cfg
);

  logic                busy, start_req, rx_we, rx_val;
  logic [POS_W-1:0]    rx_pos;
  logic [31:0]         cmd_q, counts_q;
  logic [NUM_CS-1:0]   cs_q;
  logic [BUF_BITS-1:0] buf_flat;

  spi_xact_regs #(.DATA_WORDS(DATA_WORDS), .NUM_CS(NUM_CS)) u_regs (
    .clk, .rst_n,
    .bus_we(reg_we), .bus_addr(reg_addr), .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
    .busy, .rx_we, .rx_pos, .rx_val,
    .start_req, .cmd_q, .counts_q, .cfg_q(ser_cfg), .cs_q, .buf_flat
  );

  spi_xact_ctrl #(.DATA_WORDS(DATA_WORDS), .CMD_BITS(CMD_BITS)) u_ctrl (
    .clk, .rst_n, .start_req, .cmd_q, .counts_q, .buf_flat,
    .tx_ready, .rx_valid, .rx_bit,
    .busy, .tx_valid, .tx_bit, .rx_ready, .rx_we, .rx_pos, .rx_val
  );

  for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
    assign cs_n[n] = ~cs_q[n];
  end

endmodule

// File: tb/spi_xact_seq_bench.sv
module spi_xact_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [5:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        tx_valid, tx_ready = 0, tx_bit;
  logic        rx_valid = 0, rx_ready, rx_bit = 0;
  logic [1:0]  cs_n;
  logic [31:0] ser_cfg;

  int checks = 0, fails = 0;
  logic [31:0] m_w [8];
  logic        rxpat [512];
  logic        got_tx [600];
  int got_n, rx_given, last_fire, end_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_xact_seq u_spi_xact_seq (.*);

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Serializer model: mode 0 always ready, mode 1 stalls and retries start mid-run
  task automatic run_serial(input int mode);
    logic [31:0] d;
    logic prev_stall = 0, prev_bit = 0, rdy;
    got_n = 0; rx_given = 0; last_fire = -1; end_n = -1;
    for (int cyc = 0; cyc < 5000; cyc++) begin
      if (mode == 1 && cyc == 4) begin reg_wdata = 32'h100; reg_we = 1; end
      else reg_we = 0;
      rd(6'h00, d);
      if (!d[16]) begin end_n = cyc; break; end
      if (prev_stall) chk(tx_valid && tx_bit == prev_bit, "R8 hold under stall", {31'd0, tx_bit}, {31'd0, prev_bit});
      rdy = (mode == 0) || (cyc % 3 != 0);
      tx_ready = rdy;
      if (tx_valid && rdy) begin got_tx[got_n] = tx_bit; got_n++; last_fire = cyc; end
      prev_stall = tx_valid && !rdy; prev_bit = tx_bit;
      if (rx_ready && (mode == 0 || cyc % 2 == 0)) begin
        rx_valid = 1; rx_bit = rxpat[rx_given]; rx_given++; last_fire = cyc;
      end else rx_valid = 0;
      @(negedge clk);
    end
    reg_we = 0; tx_ready = 0; rx_valid = 0;
  endtask

  function automatic logic mbyte_bit(int b, int j);
    return m_w[b/4][8*(b%4) + j];
  endfunction

  task automatic t_xfer(input logic [31:0] cmdv, input int cf, input int tf, input int rf,
                        input int mode, input int seed);
    int ec, et, er, bad, firstbad;
    logic [31:0] d, cnts;
    logic e;
    ec = (cf > 32) ? 32 : cf; et = (tf > 256) ? 256 : tf; er = (rf > 256) ? 256 : rf;
    for (int i = 0; i < 512; i++) rxpat[i] = (((i * 7 + seed) % 5) < 2);
    cnts = {8'(cf), 12'(rf), 12'(tf)};
    wr(6'h2C, cnts);
    wr(6'h04, cmdv);
    wr(6'h00, 32'h100);
    // R10: writes while busy must not land
    wr(6'h04, ~cmdv);
    wr(6'h2C, 32'h0000_1001);
    wr(6'h08, ~m_w[0]);
    run_serial(mode);
    chk(got_n == ec + et, "R3 transmit bit count", got_n, ec + et);
    bad = 0; firstbad = -1;
    for (int i = 0; i < got_n && i < ec + et; i++) begin
      e = (i < ec) ? cmdv[31 - i] : mbyte_bit((i - ec) / 8, 7 - ((i - ec) % 8));
      if (got_tx[i] != e) begin bad++; if (firstbad < 0) firstbad = i; end
    end
    chk(bad == 0, (mode == 1) ? "R2 R4 R5 bit order, restart ignored" : "R4 R5 bit order",
        firstbad, 32'hFFFF_FFFF);
    chk(rx_given == er, "R6 receive bit count", rx_given, er);
    chk(end_n == last_fire + 1, "R7 busy falls on final handshake", end_n, last_fire + 1);
    for (int i = 0; i < er; i++)
      m_w[(i/8)/4][8*((i/8)%4) + 7 - (i%8)] = rxpat[i];
    for (int k = 0; k < 8; k++) begin
      rd(6'(8 + 4*k), d);
      chk(d == m_w[k], "R6 buffer contents after receive", d, m_w[k]);
    end
    rd(6'h04, d); chk(d == cmdv, "R10 command kept", d, cmdv);
    rd(6'h2C, d); chk(d == cnts, "R10 counts kept", d, cnts);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    foreach (m_w[k]) begin rd(6'(8 + 4*k), d); chk(d == 0, "R11 data word reset", d, 0); end
    rd(6'h00, d); chk(d == 0, "R11 control reset", d, 0);
    rd(6'h2C, d); chk(d == 0, "R11 counts reset", d, 0);
    chk(cs_n == 2'b11, "R11 cs_n reset", cs_n, 2'b11);
    chk(!tx_valid && !rx_ready, "R11 streams idle", {tx_valid, rx_ready}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(6'h28, 32'hDEAD_BEEF);
    rd(6'h28, d); chk(d == 32'hDEAD_BEEF, "R1 config readback", d, 32'hDEAD_BEEF);
    chk(ser_cfg == 32'hDEAD_BEEF, "R1 ser_cfg pin", ser_cfg, 32'hDEAD_BEEF);
    wr(6'h00, 32'h0000_005A);
    rd(6'h00, d); chk(d == 32'h5A, "R1 legacy field, no start", d, 32'h5A);
    chk(!tx_valid, "R1 legacy write starts nothing", tx_valid, 0);
    for (int k = 0; k < 8; k++) begin
      m_w[k] = 32'h1122_3344 * (k + 3) ^ {k[7:0], 24'hA5C3E1};
      wr(6'(8 + 4*k), m_w[k]);
    end
    for (int k = 0; k < 8; k++) begin
      rd(6'(8 + 4*k), d); chk(d == m_w[k], "R1 data word readback", d, m_w[k]);
    end
  endtask

  task automatic t_cs();
    for (int v = 0; v < 4; v++) begin
      wr(6'h38, 32'(v));
      chk(cs_n == ~2'(v), "R9 chip select drive", cs_n, ~2'(v));
    end
    wr(6'h38, 0);
    chk(cs_n == 2'b11, "R9 chip select release", cs_n, 2'b11);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    wr(6'h2C, 0);
    wr(6'h00, 32'h100);
    rd(6'h00, d); chk(d[16] == 1, "R7 zero-count busy first cycle", d[16], 1);
    chk(!tx_valid && !rx_ready, "R3 zero counts move no bits", {tx_valid, rx_ready}, 0);
    @(negedge clk);
    rd(6'h00, d); chk(d[16] == 0, "R7 zero-count busy one cycle only", d[16], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_cs();
    t_zero();
    t_xfer(32'h9F12_3456, 8, 20, 13, 0, 1);
    t_xfer(32'hA5C3_0F81, 12, 0, 0, 1, 2);
    t_xfer(32'h0BAD_F00D, 0, 0, 24, 1, 3);
    t_xfer(32'h1234_5678, 40, 300, 400, 0, 4);
    t_xfer(32'h0000_0000, 0, 16, 0, 1, 5);
    summary();
  end
endmodule